// File: doc/BRIEF.md
# Base Address Window Decoder

This block decides, for one bus function with six base address registers and one expansion ROM register, which of those regions are currently mapped into the I/O or memory space and at what base. It takes the function's command register, the raw contents of every base register, and a per-region size and space type. Every region is qualified against a fixed set of rules: the enable bit for its space, a power-of-two size, a nonzero base, an end address that neither wraps nor runs past the top of its space, and, for the ROM, an enable bit of its own. Each region that passes gets a window.

The qualified windows are registered. An incoming transaction address and its space (I/O or memory) are matched against the registered windows in the same cycle. The result is a one-hot hit vector in which the lowest-numbered region wins when windows overlap. A one-cycle pulse marks every unmap or remap event, so downstream logic can flush anything it derived from the previous window set. Regions 0 to NUM_BARS-1 are the base registers and region NUM_BARS is the ROM. Packed vectors carry region i in bits [i*ADDR_W +: ADDR_W].

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is low and after it is released with no region qualifying, win_valid and hit are all zero, map_change is 0, and every win_base slice reads all ones.
- R2: A region of size 0 never maps. A nonzero size that is not a power of two sets that region's size_err bit combinationally, and that region never maps.
- R3: A region whose bar_is_io bit is 1 maps only while cfg_cmd bit 0 is 1. A memory region (bar_is_io bit 0) and the ROM map only while cfg_cmd bit 1 is 1. Other cfg_cmd bits have no effect.
- R4: One clock edge after its inputs settle, a mapped region shows win_valid=1 and win_base = raw AND NOT(size-1). An unmapped region shows win_base of all ones.
- R5: A region whose effective base is 0 does not map. A region whose end address (base+size-1) is not above its base does not map; this covers wrap-around and a size of 1.
- R6: An I/O region whose end address is 0x10000 or above does not map. A memory region or the ROM whose end address is all ones does not map.
- R7: The ROM region (index NUM_BARS) is always memory space. It maps only when bit 0 of its raw register is 1.
- R8: hit bit i is set in the same cycle as the access inputs when region i's registered window is valid, acc_is_io equals that region's space (1 = I/O), and acc_addr AND NOT(size-1) equals its base.
- R9: At most one hit bit is set. When several windows match, the lowest region index is reported.
- R10: map_change is 1 for exactly the cycle after a clock edge at which any win_valid bit or win_base slice changed, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd | input | 16 | Command register; bit 0 enables I/O, bit 1 enables memory |
| bar_raw | input | (NUM_BARS+1)*ADDR_W | Raw base register contents, ROM in the top slice |
| bar_size | input | (NUM_BARS+1)*ADDR_W | Region sizes in bytes; 0 means not implemented |
| bar_is_io | input | NUM_BARS | Space type per base register (1 = I/O) |
| acc_addr | input | ADDR_W | Transaction address |
| acc_is_io | input | 1 | Transaction space (1 = I/O, 0 = memory) |
| win_valid | output | NUM_BARS+1 | Registered mapped flag per region |
| win_base | output | (NUM_BARS+1)*ADDR_W | Registered effective base per region, all ones when unmapped |
| size_err | output | NUM_BARS+1 | Combinational flag for a non-power-of-two nonzero size |
| hit | output | NUM_BARS+1 | One-hot window match for the current access |
| map_change | output | 1 | One-cycle pulse on any window change |

## Verification
The qualification rules are probed one at a time. Each test has one region that would map except for a single fault: space enable off, size zero or not a power of two, base masked down to zero, a size of 1, an I/O end address just under or just past the 64K limit, a memory end address of all ones, or a ROM with its enable bit clear. This separates each rule from the others. Hit matching is tried at the first and last byte of a window and one byte past its end, and with the wrong space, which separates the mask compare from the space check. Two overlapping memory windows show the lowest-index priority both inside the overlap and in the part only the larger window covers. map_change is checked on a real remap, on the cycle after it, and on a command-bit change that leaves every window as it was.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
   localparam int MAX_BARS = 6;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;

   localparam int CMD_IO_EN  = 0;
   localparam int CMD_MEM_EN = 1;
endpackage

// File: rtl/bar_window_eval.sv
module bar_window_eval
   import bar_dec_pkg::*;
#(
   parameter int          ADDR_W = 32,
   parameter bit          IS_ROM = 1'b0,
   parameter int unsigned IO_TOP = 32'h0001_0000
) (
   input  logic [ADDR_W-1:0] raw_i,
   input  logic [ADDR_W-1:0] size_i,
   input  logic              is_io_i,
   input  logic              io_en_i,
   input  logic              mem_en_i,
   output logic              ok_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] mask_o,
   output logic              size_bad_o,
   output logic              io_o
);
   localparam logic [ADDR_W:0] IO_LIM = (ADDR_W+1)'(IO_TOP);

   logic [ADDR_W-1:0] size_m1;
   logic [ADDR_W-1:0] base_c;
   logic [ADDR_W:0]   last_c;
   logic              pow2;
   logic              rom_gate;
   space_e            kind;
   logic              space_en;
   logic              geom_ok;
   logic              limit_ok;

   generate
      if (IS_ROM) begin : g_rom
         assign rom_gate = raw_i[0];
         assign kind     = SPACE_MEM;
      end else begin : g_bar
         assign rom_gate = 1'b1;
         assign kind     = is_io_i ? SPACE_IO : SPACE_MEM;
      end
   endgenerate

   always_comb begin
      size_m1  = size_i - ADDR_W'(1);
      base_c   = raw_i & ~size_m1;
      last_c   = {1'b0, base_c} + {1'b0, size_m1};
      pow2     = (size_i != '0) && ((size_i & size_m1) == '0);
      space_en = (kind == SPACE_IO) ? io_en_i : mem_en_i;
      geom_ok  = (base_c != '0) && !last_c[ADDR_W] && (last_c[ADDR_W-1:0] > base_c);
      if (kind == SPACE_IO) limit_ok = (last_c < IO_LIM);
      else                  limit_ok = (last_c[ADDR_W-1:0] != '1);
      ok_o       = pow2 && space_en && rom_gate && geom_ok && limit_ok;
      base_o     = ok_o ? base_c : '1;
      mask_o     = ~size_m1;
      size_bad_o = (size_i != '0) && !pow2;
      io_o       = (kind == SPACE_IO);
   end
endmodule

// File: rtl/bar_hit_arbiter.sv
module bar_hit_arbiter #(
   parameter int N = 7
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   logic taken;

   always_comb begin
      taken   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         grant_o[i] = req_i[i] & ~taken;
         taken      = taken | req_i[i];
      end
   end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_dec_pkg::*;
#(
   parameter int          NUM_BARS = 6,
   parameter int          ADDR_W   = 32,
   parameter int unsigned IO_TOP   = 32'h0001_0000
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [15:0]                       cfg_cmd,
   input  logic [(NUM_BARS+1)*ADDR_W-1:0]    bar_raw,
   input  logic [(NUM_BARS+1)*ADDR_W-1:0]    bar_size,
   input  logic [NUM_BARS-1:0]               bar_is_io,
   input  logic [ADDR_W-1:0]                 acc_addr,
   input  logic                              acc_is_io,
   output logic [NUM_BARS:0]                 win_valid,
   output logic [(NUM_BARS+1)*ADDR_W-1:0]    win_base,
   output logic [NUM_BARS:0]                 size_err,
   output logic [NUM_BARS:0]                 hit,
   output logic                              map_change
);
   localparam int NREG = NUM_BARS + 1;

   initial begin
      if (NUM_BARS < 1 || NUM_BARS > MAX_BARS)
         $fatal(1, "bar_window_decoder: NUM_BARS out of range");
      if (ADDR_W < 17 || ADDR_W > 64)
         $fatal(1, "bar_window_decoder: ADDR_W out of range");
   end

   logic [NREG-1:0]           io_ext;
   logic [NREG-1:0]           nxt_valid;
   logic [NREG*ADDR_W-1:0]    nxt_base;
   logic [ADDR_W-1:0]         nxt_mask [NREG];
   logic [NREG-1:0]           nxt_io;
   logic [ADDR_W-1:0]         win_mask_q [NREG];
   logic [NREG-1:0]           win_io_q;
   logic [NREG-1:0]           req;

   assign io_ext = {1'b0, bar_is_io};

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_region
         bar_window_eval #(
            .ADDR_W (ADDR_W),
            .IS_ROM (i == NUM_BARS),
            .IO_TOP (IO_TOP)
         ) u_eval (
            .raw_i      (bar_raw[i*ADDR_W +: ADDR_W]),
            .size_i     (bar_size[i*ADDR_W +: ADDR_W]),
            .is_io_i    (io_ext[i]),
            .io_en_i    (cfg_cmd[CMD_IO_EN]),
            .mem_en_i   (cfg_cmd[CMD_MEM_EN]),
            .ok_o       (nxt_valid[i]),
            .base_o     (nxt_base[i*ADDR_W +: ADDR_W]),
            .mask_o     (nxt_mask[i]),
            .size_bad_o (size_err[i]),
            .io_o       (nxt_io[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win_mask_q[i] <= '0;
            else        win_mask_q[i] <= nxt_mask[i];
         end

         assign req[i] = win_valid[i] && (win_io_q[i] == acc_is_io) &&
                         ((acc_addr & win_mask_q[i]) == win_base[i*ADDR_W +: ADDR_W]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_valid  <= '0;
         win_base   <= '1;
         win_io_q   <= '0;
         map_change <= 1'b0;
      end else begin
         win_valid  <= nxt_valid;
         win_base   <= nxt_base;
         win_io_q   <= nxt_io;
         map_change <= (nxt_valid != win_valid) || (nxt_base != win_base);
      end
   end

   bar_hit_arbiter #(.N(NREG)) u_arb (
      .req_i   (req),
      .grant_o (hit)
   );
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
   parameter int NUM_BARS = 6,
   parameter int ADDR_W   = 32
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [15:0]                    cfg_cmd,
   input logic [(NUM_BARS+1)*ADDR_W-1:0] bar_raw,
   input logic [(NUM_BARS+1)*ADDR_W-1:0] bar_size,
   input logic [NUM_BARS-1:0]            bar_is_io,
   input logic [NUM_BARS:0]              win_valid,
   input logic [(NUM_BARS+1)*ADDR_W-1:0] win_base,
   input logic [NUM_BARS:0]              size_err,
   input logic [NUM_BARS:0]              hit,
   input logic                           map_change
);
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R9

   AST_HIT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hit & ~win_valid) == '0); // R8

   AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cmd[0] |=> ((win_valid[NUM_BARS-1:0] & $past(bar_is_io)) == '0)); // R3

   AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cmd[1] |=> (((win_valid[NUM_BARS-1:0] & ~$past(bar_is_io)) == '0) && !win_valid[NUM_BARS])); // R3

   AST_ROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bar_raw[NUM_BARS*ADDR_W] |=> !win_valid[NUM_BARS]); // R7

   AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      map_change == ((win_valid != $past(win_valid)) || (win_base != $past(win_base)))); // R10

   generate
      for (genvar i = 0; i <= NUM_BARS; i++) begin : g_chk
         AST_UNMAPPED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            !win_valid[i] |-> (win_base[i*ADDR_W +: ADDR_W] == '1)); // R4

         AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            (bar_size[i*ADDR_W +: ADDR_W] == '0) |=> !win_valid[i]); // R2

         AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            size_err[i] |=> !win_valid[i]); // R2
      end
   endgenerate
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
   .NUM_BARS (NUM_BARS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_cmd    (cfg_cmd),
   .bar_raw    (bar_raw),
   .bar_size   (bar_size),
   .bar_is_io  (bar_is_io),
   .win_valid  (win_valid),
   .win_base   (win_base),
   .size_err   (size_err),
   .hit        (hit),
   .map_change (map_change)
);

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 6;
   localparam int AW   = 32;
   localparam int NR   = NB + 1;
   localparam int ROM  = NB;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [15:0]        cfg_cmd = '0;
   logic [NR*AW-1:0]   bar_raw = '0;
   logic [NR*AW-1:0]   bar_size = '0;
   logic [NB-1:0]      bar_is_io = '0;
   logic [AW-1:0]      acc_addr = '0;
   logic               acc_is_io = 1'b0;
   logic [NR-1:0]      win_valid;
   logic [NR*AW-1:0]   win_base;
   logic [NR-1:0]      size_err;
   logic [NR-1:0]      hit;
   logic               map_change;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bar_window_decoder #(.NUM_BARS(NB), .ADDR_W(AW)) u0 (
      .clk, .rst_n, .cfg_cmd, .bar_raw, .bar_size, .bar_is_io,
      .acc_addr, .acc_is_io, .win_valid, .win_base, .size_err, .hit, .map_change
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_reg(input int i, input logic [AW-1:0] raw, input logic [AW-1:0] sz, input logic io);
      bar_raw[i*AW +: AW]  = raw;
      bar_size[i*AW +: AW] = sz;
      if (i < NB) bar_is_io[i] = io;
   endtask

   task automatic clear_all();
      bar_raw = '0; bar_size = '0; bar_is_io = '0; cfg_cmd = '0;
      tick(); tick();
   endtask

   function automatic logic [AW-1:0] base_of(input int i);
      return win_base[i*AW +: AW];
   endfunction

   task automatic probe(input logic [AW-1:0] a, input logic io);
      acc_addr = a; acc_is_io = io; #1;
   endtask

   task automatic t_reset();
      chk("R1 valid after reset", 64'(win_valid), 0);
      chk("R1 hit after reset", 64'(hit), 0);
      chk("R1 map_change after reset", 64'(map_change), 0);
      chk("R1 base after reset", 64'(base_of(0)), 64'hFFFF_FFFF);
   endtask

   task automatic t_io_basic();
      set_reg(0, 32'h0000_C001, 32'h20, 1'b1);
      cfg_cmd = 16'h0001;
      tick();
      chk("R4 io valid", 64'(win_valid[0]), 1);
      chk("R4 io base", 64'(base_of(0)), 64'hC000);
      chk("R10 pulse on remap", 64'(map_change), 1);
      tick();
      chk("R10 pulse single cycle", 64'(map_change), 0);
      probe(32'hC01F, 1'b1); chk("R8 last byte hit", 64'(hit), 64'h1);
      probe(32'hC000, 1'b1); chk("R8 first byte hit", 64'(hit), 64'h1);
      probe(32'hC020, 1'b1); chk("R8 past end no hit", 64'(hit), 0);
      probe(32'hC010, 1'b0); chk("R8 wrong space no hit", 64'(hit), 0);
      cfg_cmd = 16'h0005;
      tick();
      chk("R10 no pulse for unrelated cmd bit", 64'(map_change), 0);
      chk("R3 unrelated cmd bit keeps window", 64'(win_valid[0]), 1);
      cfg_cmd = 16'h0002;
      tick();
      chk("R3 io needs io enable", 64'(win_valid[0]), 0);
      chk("R4 unmapped base all ones", 64'(base_of(0)), 64'hFFFF_FFFF);
      chk("R10 pulse on unmap", 64'(map_change), 1);
      clear_all();
   endtask

   task automatic t_mem_gate();
      set_reg(1, 32'h8000_0000, 32'h1000, 1'b0);
      cfg_cmd = 16'h0001;
      tick();
      chk("R3 mem blocked by io-only cmd", 64'(win_valid[1]), 0);
      cfg_cmd = 16'h0002;
      tick();
      chk("R3 mem maps with mem enable", 64'(win_valid[1]), 1);
      chk("R4 mem base", 64'(base_of(1)), 64'h8000_0000);
      clear_all();
   endtask

   task automatic t_size();
      cfg_cmd = 16'h0003;
      set_reg(2, 32'h4000_0000, 32'h0, 1'b0);
      tick();
      chk("R2 size zero unmapped", 64'(win_valid[2]), 0);
      set_reg(2, 32'h4000_0000, 32'h3000, 1'b0);
      #1;
      chk("R2 size_err flagged", 64'(size_err), 64'h4);
      tick();
      chk("R2 bad size unmapped", 64'(win_valid[2]), 0);
      clear_all();
   endtask

   task automatic t_geometry();
      cfg_cmd = 16'h0003;
      set_reg(3, 32'h0000_0FFF, 32'h1000, 1'b0);
      tick();
      chk("R5 zero base unmapped", 64'(win_valid[3]), 0);
      set_reg(3, 32'h0000_1000, 32'h1, 1'b0);
      tick();
      chk("R5 size one unmapped", 64'(win_valid[3]), 0);
      set_reg(3, 32'hFFFF_F000, 32'h1000, 1'b0);
      tick();
      chk("R6 memory end all ones unmapped", 64'(win_valid[3]), 0);
      set_reg(3, 32'hFFFF_E000, 32'h1000, 1'b0);
      tick();
      chk("R6 memory just below top maps", 64'(win_valid[3]), 1);
      set_reg(4, 32'h0000_FFF0, 32'h10, 1'b1);
      tick();
      chk("R6 io end 0xFFFF maps", 64'(win_valid[4]), 1);
      set_reg(4, 32'h0001_0000, 32'h10, 1'b1);
      tick();
      chk("R6 io past 64K unmapped", 64'(win_valid[4]), 0);
      clear_all();
   endtask

   task automatic t_rom();
      cfg_cmd = 16'h0002;
      set_reg(ROM, 32'h000C_0000, 32'h1_0000, 1'b0);
      tick();
      chk("R7 rom disabled unmapped", 64'(win_valid[ROM]), 0);
      set_reg(ROM, 32'h000C_0001, 32'h1_0000, 1'b0);
      tick();
      chk("R7 rom enabled maps", 64'(win_valid[ROM]), 1);
      chk("R7 rom base", 64'(base_of(ROM)), 64'h000C_0000);
      probe(32'h000C_1234, 1'b0); chk("R7 rom memory hit", 64'(hit), 64'h40);
      probe(32'h000C_1234, 1'b1); chk("R7 rom ignores io access", 64'(hit), 0);
      cfg_cmd = 16'h0001;
      tick();
      chk("R3 rom needs mem enable", 64'(win_valid[ROM]), 0);
      clear_all();
   endtask

   task automatic t_overlap();
      cfg_cmd = 16'h0002;
      set_reg(1, 32'h8000_0000, 32'h1000, 1'b0);
      set_reg(4, 32'h8000_0000, 32'h10_0000, 1'b0);
      tick();
      probe(32'h8000_0010, 1'b0); chk("R9 lowest index wins", 64'(hit), 64'h02);
      probe(32'h8000_2000, 1'b0); chk("R9 larger window only", 64'(hit), 64'h10);
      tick();
      chk("R10 no pulse when steady", 64'(map_change), 0);
      clear_all();
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_io_basic();
      t_mem_gate();
      t_size();
      t_geometry();
      t_rom();
      t_overlap();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule